// File: doc/BRIEF.md
# Strobe Watchdog with Selectable Timeout

This block supervises a processor by watching one of its output lines. The software is expected to pull that line from high to low at regular intervals. Each such falling edge restarts an internal timeout. If no falling edge arrives before the timeout runs out, the block raises a reset request for a fixed number of ticks. If the software stays silent, it keeps raising a new request every period.

Time is measured in ticks of a one-cycle `tick_ms` strobe, which is nominally one per millisecond. A 2-bit selector chooses one of three timeout lengths. A hold input, used while the system is already held in reset, parks the watchdog so that it cannot stack extra pulses on top of that reset. The strobe is asynchronous to the clock and passes through a synchronizer before edge detection. Driving the board reset pins and resolving a three-level strap pin into the selector code are left to the surrounding logic.

Top module: `strobe_watchdog`

## Requirements
- R1: After synchronous reset, `rst_req` is low and the timeout count starts from zero, so with no strobe activity the first pulse begins after the selected number of ticks.
- R2: A high-to-low transition on `strobe_in` restarts the timeout count. The strobe passes through two synchronizing flops, so the count is cleared on the third rising clock edge after the strobe goes low.
- R3: Rising edges of `strobe_in` and a strobe held at a constant level (high or low) do not restart the count.
- R4: The timeout is selected by `tsel`: code 0 gives 150 ticks, code 1 gives 600 ticks, code 2 gives 1200 ticks, and code 3 also gives 600 ticks.
- R5: When the timeout expires, `rst_req` is high for exactly 250 ticks.
- R6: At the end of each pulse the count restarts from zero. With the strobe still silent, the next pulse starts after a further full timeout, so pulses repeat indefinitely.
- R7: A falling strobe edge during a pulse does not shorten that pulse.
- R8: While `hold_clr` is high, the count stays at zero and `rst_req` is low. Asserting it during a pulse ends the pulse on the next clock. After release, the count restarts from zero.
- R9: A new `tsel` value is sampled only when the count restarts: at reset, on a falling strobe edge, at the end of a pulse, or under `hold_clr`. A change in the middle of a period does not alter the timeout already running.
- R10: Only clock cycles with `tick_ms` high advance the timeout and pulse counts. Cycles without a tick leave both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle time-base tick |
| strobe_in | input | 1 | Asynchronous service strobe from the processor |
| tsel | input | 2 | Timeout select code (0, 1, 2, 3) |
| hold_clr | input | 1 | Holds the watchdog cleared and quiet |
| rst_req | output | 1 | Reset pulse request, active high |

## Verification
The hardest case to reach from the ports is a selector change taking effect only at a restart. It can only be seen by comparing two consecutive periods: one that started under the old code and one that started after a pulse boundary. The stimulus starts the watchdog on the short setting and switches the selector to the long setting partway into the first period. It then checks that the first pulse still comes after 150 ticks and that the following gap is 1200 ticks. A similar sequence drops the strobe in the middle of a pulse, then measures the pulse width and the next gap, to show that the edge neither cuts the pulse nor shifts the following period.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic {
        WD_WATCH = 1'b0,
        WD_PULSE = 1'b1
    } wd_state_e;

    typedef struct packed {
        wd_state_e state;
        logic      restart;
    } wd_status_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Code 3 folds onto the middle setting.
    function automatic int unsigned pick_limit(input logic [1:0]  code,
                                               input int unsigned t_short,
                                               input int unsigned t_mid,
                                               input int unsigned t_long);
        unique case (code)
            2'd0:    return t_short;
            2'd2:    return t_long;
            default: return t_mid;
        endcase
    endfunction

endpackage

// File: rtl/wd_strobe_sync.sv
module wd_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic fall
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= strobe_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
        end
    end

    assign fall = sync_q[STAGES] & ~sync_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R2

endmodule

// File: rtl/wd_limit_reg.sv
module wd_limit_reg
    import wd_pkg::*;
#(
    parameter int unsigned T_SHORT = 150,
    parameter int unsigned T_MID   = 600,
    parameter int unsigned T_LONG  = 1200,
    parameter int unsigned CNT_W   = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       tsel,
    input  logic             load,
    output logic [CNT_W-1:0] limit_q
);
    logic [CNT_W-1:0] limit_d;

    always_comb begin
        limit_d = CNT_W'(pick_limit(tsel, T_SHORT, T_MID, T_LONG));
    end

    always_ff @(posedge clk) begin
        if (rst || load) limit_q <= limit_d;
    end

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(limit_q)); // R9

    AST_LIMIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        load |=> (limit_q == CNT_W'(T_SHORT) || limit_q == CNT_W'(T_MID)
                  || limit_q == CNT_W'(T_LONG))); // R4

endmodule

// File: rtl/wd_core.sv
module wd_core
    import wd_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 250,
    parameter int unsigned CNT_W       = 11,
    parameter int unsigned PW          = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             fall,
    input  logic             hold_clr,
    input  logic [CNT_W-1:0] limit_q,
    output wd_status_t       status,
    output logic             rst_req
);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pcnt_q;
    logic             cnt_last;
    logic             pulse_last;

    assign cnt_last   = (cnt_q == limit_q - CNT_W'(1));
    assign pulse_last = (pcnt_q == PULSE_LAST);

    always_comb begin
        status.state   = state_q;
        status.restart = hold_clr
                       | ((state_q == WD_WATCH) & fall)
                       | ((state_q == WD_PULSE) & tick_ms & pulse_last);
    end

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            state_q <= WD_WATCH;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            unique case (state_q)
                WD_WATCH: begin
                    if (fall) begin
                        cnt_q <= '0;
                    end else if (tick_ms) begin
                        if (cnt_last) begin
                            state_q <= WD_PULSE;
                            cnt_q   <= '0;
                            pcnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                WD_PULSE: begin
                    if (fall) cnt_q <= '0;
                    if (tick_ms) begin
                        if (pulse_last) begin
                            state_q <= WD_WATCH;
                            cnt_q   <= '0;
                            pcnt_q  <= '0;
                        end else begin
                            pcnt_q <= pcnt_q + PW'(1);
                        end
                    end
                end
                default: state_q <= WD_WATCH;
            endcase
        end
    end

    assign rst_req = (state_q == WD_PULSE);

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> (!rst_req && cnt_q == '0)); // R8

    AST_PULSE_NO_CUT: assert property (@(posedge clk) disable iff (rst)
        (rst_req && fall && !hold_clr && !tick_ms) |=> rst_req); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit_q); // R4

    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!tick_ms && !fall && !hold_clr) |=> ($stable(cnt_q) && $stable(pcnt_q))); // R10

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (cnt_q == '0)); // R6

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && fall) |=> (cnt_q == '0 && !rst_req)); // R2

    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= PULSE_LAST); // R5

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import wd_pkg::*;
#(
    parameter int unsigned T_SHORT     = 150,
    parameter int unsigned T_MID       = 600,
    parameter int unsigned T_LONG      = 1200,
    parameter int unsigned PULSE_TICKS = 250,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic       strobe_in,
    input  logic [1:0] tsel,
    input  logic       hold_clr,
    output logic       rst_req
);
    localparam int unsigned T_MAX = max3(T_SHORT, T_MID, T_LONG);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);
    localparam int unsigned PW    = $clog2(PULSE_TICKS + 1);

    logic             fall;
    logic [CNT_W-1:0] limit_q;
    wd_status_t       status;

    wd_strobe_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (strobe_in),
        .fall      (fall)
    );

    wd_limit_reg #(
        .T_SHORT (T_SHORT),
        .T_MID   (T_MID),
        .T_LONG  (T_LONG),
        .CNT_W   (CNT_W)
    ) u_limit (
        .clk     (clk),
        .rst     (rst),
        .tsel    (tsel),
        .load    (status.restart),
        .limit_q (limit_q)
    );

    wd_core #(
        .PULSE_TICKS (PULSE_TICKS),
        .CNT_W       (CNT_W),
        .PW          (PW)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick_ms  (tick_ms),
        .fall     (fall),
        .hold_clr (hold_clr),
        .limit_q  (limit_q),
        .status   (status),
        .rst_req  (rst_req)
    );

    AST_REQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        rst_req == (status.state == WD_PULSE)); // R5

endmodule

// File: tb/sim_strobe_watchdog.sv
`timescale 1ns/1ps
module sim_strobe_watchdog;

    localparam int PULSE = 250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b1;
    logic       strobe_in = 1'b1;
    logic [1:0] tsel = 2'd0;
    logic       hold_clr = 1'b0;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    strobe_watchdog u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_ms   (tick_ms),
        .strobe_in (strobe_in),
        .tsel      (tsel),
        .hold_clr  (hold_clr),
        .rst_req   (rst_req)
    );

    function automatic int limit_of(input logic [1:0] c);
        if (c == 2'd0) return 150;
        if (c == 2'd2) return 1200;
        return 600;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_high(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < 5000);
    endtask

    task automatic wait_low(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_req && n < 5000);
    endtask

    task automatic t_reset();
        int n;
        tsel = 2'd0; strobe_in = 1'b1; hold_clr = 1'b0; tick_ms = 1'b1;
        do_reset();
        check("R1 rst_req low after reset", int'(rst_req), 0);
        wait_high(n);
        check("R1 first pulse after reset", n, 150);
    endtask

    task automatic t_timeouts();
        int n;
        for (int c = 0; c < 4; c++) begin
            tsel = 2'(c);
            do_reset();
            wait_high(n);
            check($sformatf("R4 timeout code %0d", c), n, limit_of(2'(c)));
            wait_low(n);
            check("R5 pulse width", n, PULSE);
            wait_high(n);
            check("R6 repeat gap", n, limit_of(2'(c)));
        end
    endtask

    task automatic t_fall_restart();
        int n = 0;
        tsel = 2'd0; strobe_in = 1'b1;
        do_reset();
        repeat (100) @(negedge clk);
        strobe_in = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (n == 50) strobe_in = 1'b1;
        end while (!rst_req && n < 5000);
        check("R2 restart by falling edge, R3 rising ignored", n, 153);
    endtask

    task automatic t_static_low();
        int n;
        tsel = 2'd0; strobe_in = 1'b0;
        do_reset();
        wait_high(n);
        check("R3 static low strobe", n, 150);
        strobe_in = 1'b1;
    endtask

    task automatic t_pulse_edge();
        int n;
        int w = 1;
        tsel = 2'd0; strobe_in = 1'b1;
        do_reset();
        wait_high(n);
        do begin
            @(negedge clk);
            w++;
            if (w == 100) strobe_in = 1'b0;
        end while (rst_req && w < 5000);
        check("R7 pulse kept full length", w - 1, PULSE);
        wait_high(n);
        check("R7 gap after pulse with edge", n, 150);
        strobe_in = 1'b1;
    endtask

    task automatic t_hold();
        int n;
        int seen = 0;
        tsel = 2'd0; strobe_in = 1'b1;
        do_reset();
        hold_clr = 1'b1;
        repeat (2000) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check("R8 no pulse while held", seen, 0);
        hold_clr = 1'b0;
        wait_high(n);
        check("R8 restart after hold release", n, 150);
        hold_clr = 1'b1;
        @(negedge clk);
        check("R8 hold ends pulse", int'(rst_req), 0);
        hold_clr = 1'b0;
    endtask

    task automatic t_sel_change();
        int n = 0;
        tsel = 2'd0;
        do_reset();
        do begin
            @(negedge clk);
            n++;
            if (n == 50) tsel = 2'd2;
        end while (!rst_req && n < 5000);
        check("R9 running period keeps old selection", n, 150);
        wait_low(n);
        wait_high(n);
        check("R9 new selection after restart", n, 1200);
    endtask

    task automatic t_tick();
        int n;
        int seen = 0;
        tsel = 2'd0; tick_ms = 1'b1;
        do_reset();
        repeat (100) @(negedge clk);
        tick_ms = 1'b0;
        repeat (500) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check("R10 no progress without ticks", seen, 0);
        tick_ms = 1'b1;
        wait_high(n);
        check("R10 remaining ticks", n, 50);
    endtask

    initial begin
        t_reset();
        t_timeouts();
        t_fall_restart();
        t_static_low();
        t_pulse_edge();
        t_hold();
        t_sel_change();
        t_tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule